// File: doc/BRIEF.md
# Ternary Cascaded-Bridge Staircase Gate Generator

This block produces the twelve gate signals for a single-phase inverter made from three series-connected H-bridge cells. The cells' DC supplies have weights of 1, 3 and 9 units, so the summed cell voltages can reach 27 distinct levels, from -13 to +13 units. A phase counter runs through one output period, and the current position selects a signed target level. That level rises and falls as a staircase that tracks a sine envelope, with the step instants placed on a sine relation.

Each level is split into three balanced-ternary digits, one digit per cell. Each digit maps to a drive pattern for that cell's two legs. Before either switch of a leg turns on, both switches of that leg are held off for a parameterised dead interval. The heaviest cell therefore changes state only a few times per period, while the unit cell toggles at almost every step.

Clearing the enable input, or raising the fault input, turns every gate off at the next clock and sends the waveform back to the start of its period. The nominal period is one 50 Hz cycle, set by the quarter-period length in clocks.

Top module: `tern_stair_gen`

## Requirements
- R1: While `rst` is high, all twelve `gates` are 0 and `level` is 0.
- R2: One period lasts 4*QUARTER_CYC clocks. The first enabled clock after a stop is phase 0, and `level` shows the target for phase p one clock after that phase is counted. Phase index i (0..Q-1) is the offset in the first and third quarters and Q-1-offset in the second and fourth. The magnitude is the count of k in 1..13 with i >= floor(F_k*Q/1024). The level is positive in the first half and negated in the second half. F = 25, 75, 126, 178, 230, 285, 341, 401, 465, 534, 612, 707, 843.
- R3: `level` is a 6-bit two's complement value in -13..+13, and between consecutive enabled clocks it moves by at most one unit.
- R4: Cell c (c = 0, 1, 2, weight 3^c) receives digit d_c in {-1, 0, +1}, with 9*d_2 + 3*d_1 + d_0 equal to `level`.
- R5: Cell c drives gates[4c+3:4c]. Bit 0 is the left-high switch, bit 1 left-low, bit 2 right-high and bit 3 right-low. Digit +1 gives 4'b1001, digit -1 gives 4'b0110 and digit 0 gives 4'b1010. A cell shows this pattern once `level` has been steady for DEAD_CYC+1 enabled clocks.
- R6: The high and low switches of one leg are never on in the same cycle.
- R7: Before a leg turns on either switch, both of its switches have been off for at least DEAD_CYC clocks. This applies after a side change and also after a restart.
- R8: Each clock edge that sees `enable` low or `fault` high leaves all gates off and `level` at 0, and restarts the phase from 0.
- R9: In every uninterrupted period, the weight-9 cell turns on its left-high switch exactly once and its right-high switch exactly once. The weight-1 cell turns on its left-high switch at least four times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run request; low stops the waveform |
| fault | input | 1 | Protection input; high forces all gates off |
| gates | output | 12 | Switch gate drives, four per cell |
| level | output | 6 | Signed target level currently commanded |

## Verification
A wrong phase count or a wrong threshold shows on `level` within one clock of the misplaced step. A wrong digit split or a wrong gate mapping shows on `gates` within DEAD_CYC+1 clocks of any level change. A broken dead-time counter shows at the first switch-on after a side change, either as a short all-off gap or as both switches of a leg on together. A shutdown path that does not act shows as nonzero gates at the first sample after `fault` or a low `enable`. Per-period switch-on counts of the heaviest and lightest cells catch errors in the cell ordering.

// File: rtl/tern_pkg.sv
package tern_pkg;
  localparam int NCELL = 3;
  localparam int LVL_MAX = 13;
  localparam int NSTEP = 13;
  localparam int LVL_W = 6;
  localparam longint FRAC_SCALE = 1024;

  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b10
  } digit_t;

  // Sine-derived step instant of level k, as a fraction of a quarter period (x1024)
  function automatic longint step_frac(int k);
    case (k)
      1:  return 25;
      2:  return 75;
      3:  return 126;
      4:  return 178;
      5:  return 230;
      6:  return 285;
      7:  return 341;
      8:  return 401;
      9:  return 465;
      10: return 534;
      11: return 612;
      12: return 707;
      13: return 843;
      default: return FRAC_SCALE;
    endcase
  endfunction

  // Clock-count threshold within a quarter of length q
  function automatic longint step_thr(int k, longint q);
    return (step_frac(k) * q) / FRAC_SCALE;
  endfunction

  // Balanced-ternary digit 'pos': ordinary ternary digits of level+13, shifted by one
  function automatic digit_t level_digit(logic signed [LVL_W-1:0] lvl, int pos);
    int v;
    v = int'(lvl) + LVL_MAX;
    for (int i = 0; i < NCELL; i++) begin
      if (i < pos) v = v / 3;
    end
    case (v % 3)
      0: return DIG_NEG;
      1: return DIG_ZERO;
      default: return DIG_POS;
    endcase
  endfunction

  function automatic int digit_val(digit_t d);
    case (d)
      DIG_POS: return 1;
      DIG_NEG: return -1;
      default: return 0;
    endcase
  endfunction

  // {right leg high wanted, left leg high wanted}
  function automatic logic [1:0] leg_wants(digit_t d);
    case (d)
      DIG_POS: return 2'b01;
      DIG_NEG: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/tern_phase.sv
module tern_phase
  import tern_pkg::*;
#(
  parameter int QUARTER_CYC = 250000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  output logic signed [LVL_W-1:0] level_o
);
  localparam int QW = $clog2(QUARTER_CYC + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUARTER_CYC - 1);

  logic [1:0]              quad_q;
  logic [QW-1:0]           off_q;
  logic [QW-1:0]           idx;
  logic [4:0]              mag;
  logic signed [LVL_W-1:0] mag_s;
  logic signed [LVL_W-1:0] lvl_next;
  wire                     quarter_end = (off_q == QLAST);

  // mirrored index in quarters 1 and 3
  assign idx = quad_q[0] ? (QLAST - off_q) : off_q;

  always_comb begin
    mag = '0;
    for (int k = 1; k <= NSTEP; k++) begin
      if (longint'(idx) >= step_thr(k, longint'(QUARTER_CYC))) mag = mag + 5'd1;
    end
  end

  assign mag_s    = {1'b0, mag};
  assign lvl_next = quad_q[1] ? -mag_s : mag_s;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      quad_q  <= '0;
      off_q   <= '0;
      level_o <= '0;
    end else begin
      level_o <= lvl_next;
      if (quarter_end) begin
        off_q  <= '0;
        quad_q <= quad_q + 2'd1;
      end else begin
        off_q <= off_q + QW'(1);
      end
    end
  end

  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> ((level_o == $past(level_o)) ||
                             (level_o == $past(level_o) + 6'sd1) ||
                             (level_o == $past(level_o) - 6'sd1)));

  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    (level_o <= 6'sd13) && (level_o >= -6'sd13));

  a_r8_level_clear: assert property (@(posedge clk) disable iff (rst)
    !run |=> (level_o == 6'sd0));
endmodule

// File: rtl/tern_split.sv
module tern_split
  import tern_pkg::*;
(
  input  logic signed [LVL_W-1:0] level_i,
  output digit_t                  dig_o [NCELL]
);
  for (genvar c = 0; c < NCELL; c++) begin : g_dig
    assign dig_o[c] = level_digit(level_i, c);
  end
endmodule

// File: rtl/tern_leg.sv
module tern_leg #(
  parameter int DEAD_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic want_hi,
  output logic g_hi,
  output logic g_lo
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] WAIT_INIT = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] GAP_SAT   = CW'(DEAD_CYC);

  logic          on_q;
  logic          side_q;
  logic [CW-1:0] wait_q;
  logic [CW-1:0] off_run;
  wire           side_flip = on_q && (side_q != want_hi);
  wire           leg_off   = !g_hi && !g_lo;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      on_q   <= 1'b0;
      side_q <= want_hi;
      wait_q <= WAIT_INIT;
    end else if (on_q) begin
      if (side_flip) begin
        on_q   <= 1'b0;
        side_q <= want_hi;
        wait_q <= WAIT_INIT;
      end
    end else begin
      side_q <= want_hi;
      if (wait_q == '0) on_q <= 1'b1;
      else              wait_q <= wait_q - CW'(1);
    end
  end

  assign g_hi = on_q & side_q;
  assign g_lo = on_q & ~side_q;

  // independent gap counter used only by the checks below
  always_ff @(posedge clk) begin
    if (rst) off_run <= '0;
    else if (leg_off) begin
      if (off_run != GAP_SAT) off_run <= off_run + CW'(1);
    end else off_run <= '0;
  end

  a_r7_dead_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(g_hi) || $rose(g_lo)) |-> (off_run >= GAP_SAT));

  a_r7_flip_goes_off: assert property (@(posedge clk) disable iff (rst)
    (side_flip && run) |=> (!g_hi && !g_lo));

  a_r8_force_off: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!g_hi && !g_lo));

  a_r6_one_side: assert property (@(posedge clk) disable iff (rst)
    $countones({g_hi, g_lo}) <= 1);
endmodule

// File: rtl/tern_cell.sv
module tern_cell
  import tern_pkg::*;
#(
  parameter int DEAD_CYC = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  digit_t     dig,
  output logic [3:0] gate
);
  logic [1:0] want;
  assign want = leg_wants(dig);

  // leg 0 = left (bits 0,1), leg 1 = right (bits 2,3)
  for (genvar l = 0; l < 2; l++) begin : g_leg
    tern_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk    (clk),
      .rst    (rst),
      .run    (run),
      .want_hi(want[l]),
      .g_hi   (gate[2*l]),
      .g_lo   (gate[2*l+1])
    );
  end
endmodule

// File: rtl/tern_stair_gen.sv
module tern_stair_gen
  import tern_pkg::*;
#(
  parameter int QUARTER_CYC = 250000,
  parameter int DEAD_CYC    = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              fault,
  output logic [11:0]       gates,
  output logic signed [5:0] level
);
  wire    run = enable && !fault;
  digit_t dig [NCELL];

  tern_phase #(.QUARTER_CYC(QUARTER_CYC)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .level_o(level)
  );

  tern_split u_split (
    .level_i(level),
    .dig_o  (dig)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    tern_cell #(.DEAD_CYC(DEAD_CYC)) u_cell (
      .clk (clk),
      .rst (rst),
      .run (run),
      .dig (dig[c]),
      .gate(gates[4*c +: 4])
    );
  end

  a_r4_digit_sum: assert property (@(posedge clk) disable iff (rst)
    (9 * digit_val(dig[2]) + 3 * digit_val(dig[1]) + digit_val(dig[0])) == int'(level));

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (gates == 12'd0) && (level == 6'sd0));
endmodule

// File: tb/tern_stair_gen_test.sv
module tern_stair_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q   = 512;
  localparam int D   = 4;
  localparam int PER = 4 * Q;

  logic              clk = 1'b0;
  logic              rst, enable, fault;
  logic [11:0]       gates;
  logic signed [5:0] level;

  tern_stair_gen #(.QUARTER_CYC(Q), .DEAD_CYC(D)) uut (
    .clk(clk), .rst(rst), .enable(enable), .fault(fault),
    .gates(gates), .level(level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0, chk_on = 0;

  task automatic chk(string req, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // ---- reference functions written from the requirements ----
  function automatic int frac_of(int k);
    int f [13] = '{25, 75, 126, 178, 230, 285, 341, 401, 465, 534, 612, 707, 843};
    return f[k-1];
  endfunction

  function automatic int ref_level(int p);
    int qd = p / Q, o = p % Q, i, m = 0;
    i = (qd % 2 == 1) ? (Q - 1 - o) : o;
    for (int k = 13; k >= 1; k--) begin
      if (i >= (frac_of(k) * Q) / 1024) begin m = k; break; end
    end
    return (qd >= 2) ? -m : m;
  endfunction

  function automatic logic [11:0] ref_gates(int lvl);
    logic [11:0] g;
    int x = lvl, r;
    for (int c = 0; c < 3; c++) begin
      r = ((x % 3) + 3) % 3;
      if (r == 2) r = -1;
      x = (x - r) / 3;
      g[4*c +: 4] = (r == 1) ? 4'b1001 : (r == -1) ? 4'b0110 : 4'b1010;
    end
    return g;
  endfunction

  // ---- cycle model of the requirement timing ----
  int bc = 0, exp_lvl = 0, sc = 0;
  bit prev_run = 0;
  always @(posedge clk) begin
    int nl;
    if (rst || !enable || fault) begin
      bc = 0; exp_lvl = 0; sc = 0; prev_run = 0;
    end else begin
      nl = ref_level(bc);
      sc = (nl == exp_lvl) ? sc + 1 : 0;
      exp_lvl = nl;
      bc = (bc + 1) % PER;
      prev_run = 1;
    end
  end

  // ---- sampled checks away from the active edge ----
  int offc [6];
  logic [11:0] g_prev = '0;
  int lvl_prev = 0;
  bit prev_ran = 0, clean = 0;
  int top_pos = 0, top_neg = 0, bot_pos = 0;
  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R2", int'(level) == exp_lvl, int'(level), exp_lvl);
      if (prev_run && prev_ran)
        chk("R3", (int'(level) - lvl_prev <= 1) && (lvl_prev - int'(level) <= 1), int'(level), lvl_prev);
      if (!prev_run) chk("R8", gates == 12'd0, int'(gates), 0);
      if (prev_run && sc >= D + 1) chk("R5", gates == ref_gates(exp_lvl), int'(gates), int'(ref_gates(exp_lvl)));
      for (int l = 0; l < 6; l++) begin
        bit h = gates[2*l], lo = gates[2*l+1];
        bit was_off = !g_prev[2*l] && !g_prev[2*l+1];
        chk("R6", !(h && lo), {h, lo}, 0);
        if ((h || lo) && was_off) chk("R7", offc[l] >= D, offc[l], D);
        offc[l] = (!h && !lo) ? offc[l] + 1 : 0;
      end
      if (!prev_run) clean = 0;
      if (gates[8]  && !g_prev[8])  top_pos++;
      if (gates[10] && !g_prev[10]) top_neg++;
      if (gates[0]  && !g_prev[0])  bot_pos++;
      if (prev_run && bc == 1) begin
        if (clean) begin
          chk("R9", top_pos == 1, top_pos, 1);
          chk("R9", top_neg == 1, top_neg, 1);
          chk("R9", bot_pos >= 4, bot_pos, 4);
        end
        top_pos = 0; top_neg = 0; bot_pos = 0; clean = 1;
      end
      g_prev = gates;
      lvl_prev = int'(level);
      prev_ran = prev_run;
    end
  end

  // ---- stimulus ----
  initial begin
    int r;
    void'($urandom(32'd2024));
    rst = 1; enable = 0; fault = 0;
    repeat (4) @(negedge clk);
    chk("R1", gates == 12'd0, int'(gates), 0);
    chk("R1", level == 6'sd0, int'(level), 0);
    chk_on = 1;
    rst = 0;
    repeat (10) @(negedge clk);
    enable = 1;
    repeat (3 * PER) @(negedge clk);
    // directed: fault at positive peak
    while (exp_lvl != 13) @(negedge clk);
    fault = 1;
    @(negedge clk);
    chk("R8", gates == 12'd0, int'(gates), 0);
    chk("R8", level == 6'sd0, int'(level), 0);
    repeat (5) @(negedge clk);
    fault = 0;
    // directed: enable drop at negative peak
    while (exp_lvl != -13) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk("R8", gates == 12'd0, int'(gates), 0);
    enable = 1;
    // directed: single-cycle fault in mid staircase
    while (exp_lvl != 6) @(negedge clk);
    fault = 1;
    @(negedge clk);
    fault = 0;
    chk("R8", level == 6'sd0, int'(level), 0);
    repeat (PER / 2) @(negedge clk);
    // random fault pulses and enable drops
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      r = $urandom_range(999);
      if (r < 3) fault = 1;
      else if (r < 300) fault = 0;
      else if (r < 302) enable = 0;
      else if (r < 380) enable = 1;
    end
    fault = 0; enable = 1;
    repeat (2 * PER + 10) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1'b0, 0, 1);
    finish_up();
  end
endmodule